// File: doc/BRIEF.md
# Indexed Effective Address Generator with Uncorrected-Page Read

This block forms the effective address for the indexed addressing modes of an 8-bit processor with a 16-bit address bus. It handles three modes: zero page indexed, absolute indexed and post-indexed indirect. For the indirect mode, the caller supplies the pointer that was already fetched from memory as the base. The caller pulses `start` with the base, the index value and an access class. The block then drives the bus address for one or two cycles.

When the index carry has not yet reached the high byte, the block first presents the summed low byte with the original high byte and raises a read strobe for this throw-away cycle. In the following cycle it presents the corrected address with `done`. This extra cycle happens only on a page crossing for plain reads. It happens on every write, read-modify-write and probe access in the absolute and indirect modes. Zero page indexing never crosses a page, so it never has the extra cycle.

Top module: `idx_addr_gen`

## Requirements
- R1: After reset, and whenever no sequence is running, `dummy_rd` and `done` are 0 and `bus_addr` is 0.
- R2: With `mode` = 2'b00 (zero page indexed), the final address is {8'h00, (base[7:0] + index) mod 256}. `base[15:8]` is ignored and no dummy cycle occurs for any access class. `done` is high in the cycle after `start`.
- R3: With `mode` = 2'b01 (absolute indexed), 2'b10 (post-indexed indirect) or 2'b11 (treated as absolute), the final address is (base + index) mod 65536. Its high byte is the base high byte plus the carry out of the low-byte sum.
- R4: For `acc` = 2'b00 (read) in a non-zero-page mode without a carry out of the low byte, no dummy cycle occurs and `done` is high with the final address in the cycle after `start`.
- R5: For a read in a non-zero-page mode with a carry out of the low byte, the cycle after `start` has `dummy_rd` = 1 and `bus_addr` = {base[15:8], low sum}. The next cycle has `done` = 1 with the final address.
- R6: For `acc` = 2'b01 (write) or 2'b10 (read-modify-write) in a non-zero-page mode, the dummy cycle at {base[15:8], low sum} always occurs and is followed by the `done` cycle.
- R7: For `acc` = 2'b11 (probe, for no-operation forms), non-zero-page modes always take the dummy cycle and then `done`; zero page mode goes straight to `done`.
- R8: A `start` pulse while a sequence is in progress is ignored: the running sequence completes unchanged and the block is idle in the cycle after `done`.
- R9: `dummy_rd` and `done` are never high together. A dummy cycle is always followed directly by a `done` cycle with the same low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation (accepted only when idle) |
| mode | input | 2 | 00 zero page indexed, 01 absolute indexed, 10 post-indexed indirect, 11 as absolute |
| acc | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 probe |
| base | input | 16 | Base address or fetched pointer |
| index | input | 8 | X or Y index value |
| bus_addr | output | 16 | Address presented to the bus |
| dummy_rd | output | 1 | Read strobe for the uncorrected-page cycle |
| done | output | 1 | Final address is on `bus_addr` this cycle |

## Verification
A wrong carry or a wrong latched high byte shows on `bus_addr` in the `done` cycle, one or two cycles after `start`. A wrong dummy decision shows at once as `dummy_rd` rising in the cycle after `start` when it should not, or staying low when it should, which also moves `done` by one cycle. A stuck sequencer state shows as `bus_addr` not returning to zero, or as `dummy_rd` and `done` overlapping, in the cycle after the expected `done`.

// File: rtl/idx_addr_gen.sv
module idx_addr_gen #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [1:0]      acc,
  input  logic [2*DW-1:0] base,
  input  logic [DW-1:0]   index,
  output logic [2*DW-1:0] bus_addr,
  output logic            dummy_rd,
  output logic            done
);
  localparam int AW = 2 * DW;
  localparam logic [1:0] S_IDLE = 2'd0, S_DUM = 2'd1, S_FIN = 2'd2;
  localparam logic [1:0] A_READ = 2'b00;

  logic [1:0]    st;
  logic [DW-1:0] lo_q, raw_hi_q, fin_hi_q;
  logic          zp_q;
  logic [1:0]    acc_q;

  logic [DW:0]   lo_sum;
  logic          carry, is_zp, need_dummy;
  logic [DW-1:0] raw_hi;

  assign lo_sum     = {1'b0, base[DW-1:0]} + {1'b0, index};
  assign carry      = lo_sum[DW];
  assign is_zp      = (mode == 2'b00);
  assign raw_hi     = is_zp ? '0 : base[AW-1:DW];
  assign need_dummy = !is_zp && ((acc != A_READ) || carry);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      lo_q     <= '0;
      raw_hi_q <= '0;
      fin_hi_q <= '0;
      zp_q     <= 1'b0;
      acc_q    <= A_READ;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          lo_q     <= lo_sum[DW-1:0];
          raw_hi_q <= raw_hi;
          fin_hi_q <= raw_hi + {{(DW-1){1'b0}}, carry & ~is_zp};
          zp_q     <= is_zp;
          acc_q    <= acc;
          st       <= need_dummy ? S_DUM : S_FIN;
        end
        S_DUM:   st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dummy_rd = (st == S_DUM);
  assign done     = (st == S_FIN);
  assign bus_addr = dummy_rd ? {raw_hi_q, lo_q} :
                    done     ? {fin_hi_q, lo_q} : '0;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!dummy_rd && !done) |-> (bus_addr == '0));  // R1
  AST_ZP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zp_q) |-> (bus_addr[AW-1:DW] == '0));  // R2
  AST_READ_DUMMY_CROSSES: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy_rd && acc_q == A_READ) |=> (bus_addr[AW-1:DW] != $past(bus_addr[AW-1:DW])));  // R5
  AST_NONREAD_VIA_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !zp_q && acc_q != A_READ) |-> $past(dummy_rd));  // R6
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dummy_rd, done}));  // R9
  AST_DUMMY_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_rd |=> (done && bus_addr[DW-1:0] == $past(bus_addr[DW-1:0])));  // R9
endmodule

// File: tb/sim_idx_addr_gen.sv
module sim_idx_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [1:0]  acc = 2'b00;
  logic [15:0] base = 16'h0;
  logic [7:0]  index = 8'h0;
  logic [15:0] bus_addr;
  logic        dummy_rd, done;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  idx_addr_gen u0 (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .acc(acc),
                   .base(base), .index(index), .bus_addr(bus_addr),
                   .dummy_rd(dummy_rd), .done(done));

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_final(input logic [1:0] m, input logic [15:0] b, input logic [7:0] i);
    logic [7:0] l;
    l = b[7:0] + i;
    if (m == 2'b00) return {8'h00, l};
    return b + {8'h00, i};
  endfunction

  // checks {dummy_rd, done, bus_addr} per cycle
  task automatic run(input string req, input logic [1:0] m, input logic [1:0] a,
                     input logic [15:0] b, input logic [7:0] i,
                     input logic exp_dummy, input logic [15:0] dummy_addr);
    @(negedge clk);
    mode = m; acc = a; base = b; index = i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (exp_dummy) begin
      chk({req, " dummy cycle"}, {dummy_rd, done, bus_addr}, {2'b10, dummy_addr});
      @(negedge clk);
    end
    chk({req, " final"}, {dummy_rd, done, bus_addr}, {2'b01, ref_final(m, b, i)});
    @(negedge clk);
    chk({req, " back idle R1"}, {dummy_rd, done, bus_addr}, 18'h0);
  endtask

  task automatic t_reset;
    chk("R1 reset", {dummy_rd, done, bus_addr}, 18'h0);
  endtask
  task automatic t_zero_page;
    run("R2 zp wrap", 2'b00, 2'b00, 16'h00F0, 8'h20, 1'b0, 16'h0);
    run("R2 zp high ignored", 2'b00, 2'b00, 16'h3480, 8'h05, 1'b0, 16'h0);
    run("R2 zp rmw no dummy", 2'b00, 2'b10, 16'h12FF, 8'h01, 1'b0, 16'h0);
  endtask
  task automatic t_read_same_page;
    run("R4 R3 abs read", 2'b01, 2'b00, 16'h2010, 8'h05, 1'b0, 16'h0);
    run("R4 indirect read", 2'b10, 2'b00, 16'h5500, 8'hFF, 1'b0, 16'h0);
  endtask
  task automatic t_read_cross;
    run("R5 R3 R9 abs read cross", 2'b01, 2'b00, 16'h20F0, 8'h20, 1'b1, 16'h2010);
    run("R5 indirect wrap top", 2'b10, 2'b00, 16'hFFF0, 8'h11, 1'b1, 16'hFF01);
  endtask
  task automatic t_write_rmw;
    run("R6 write same page", 2'b01, 2'b01, 16'h3000, 8'h01, 1'b1, 16'h3001);
    run("R6 rmw cross", 2'b11, 2'b10, 16'h30FF, 8'h01, 1'b1, 16'h3000);
    run("R6 rmw indirect", 2'b10, 2'b10, 16'h7720, 8'h00, 1'b1, 16'h7720);
  endtask
  task automatic t_probe;
    run("R7 probe abs", 2'b01, 2'b11, 16'h4000, 8'h02, 1'b1, 16'h4002);
    run("R7 probe zp", 2'b00, 2'b11, 16'h4080, 8'h02, 1'b0, 16'h0);
  endtask
  task automatic t_busy_start;
    @(negedge clk);
    mode = 2'b01; acc = 2'b00; base = 16'h10F0; index = 8'h20; start = 1'b1;
    @(negedge clk);
    mode = 2'b01; acc = 2'b10; base = 16'h6666; index = 8'h01;
    chk("R8 dummy while start held", {dummy_rd, done, bus_addr}, {2'b10, 16'h1010});
    @(negedge clk);
    start = 1'b0;
    chk("R8 done unchanged", {dummy_rd, done, bus_addr}, {2'b01, 16'h1110});
    @(negedge clk);
    chk("R8 idle after done", {dummy_rd, done, bus_addr}, 18'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_zero_page;
    t_read_same_page;
    t_read_cross;
    t_write_rmw;
    t_probe;
    t_busy_start;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule